// File: doc/BRIEF.md
# Byte-Lane Write Strobe Decoder

This block turns the write controls of a 36-bit synchronous static RAM into four registered write strobes, one for each 9-bit byte lane of the word. It takes three chip-enable inputs, a global-write input, a byte-write enable and four per-lane byte selects. All of these controls are active-low, and the block samples them on the rising clock edge. It also produces a 36-bit expanded write mask and a power-down indication. The power-down indication is raised while the device is not selected.

The storage array sits downstream of this block. It uses the lane strobes, or the expanded mask, as its internal write pulse. No external write strobe exists. The controls sampled on one rising edge decide the strobes that stay valid for exactly the following clock cycle. A global write takes precedence over every per-lane control. A per-lane write happens only when the byte-write enable qualifies the lane selects. A write may cover one, two, three or all four lanes. Deselecting the device silences every strobe within one cycle.

Top module: `lane_wr_decode`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `lane_wr` = 0, `wr_mask` = 0 and `pwr_down` = 1.
- R2: Suppose all three `ce_n` inputs are low and `gw_n` is low at a rising edge. Then `lane_wr` is 4'b1111 for the following cycle, whatever `bwe_n` and `bw_n` show.
- R3: Suppose all `ce_n` are low, `gw_n` is high and `bwe_n` is low at a rising edge. Then for every lane i, `lane_wr[i]` is 1 for the following cycle exactly when `bw_n[i]` is 0. Lane 0 maps to `bw_n[0]`, lane 3 to `bw_n[3]`, and any subset of lanes from none to all four is possible.
- R4: Suppose all `ce_n` are low and both `gw_n` and `bwe_n` are high at a rising edge. The cycle is then a read, and `lane_wr` is 0 for the following cycle whatever `bw_n` shows.
- R5: Suppose any `ce_n` bit is high at a rising edge. Then `lane_wr` is 0 and `pwr_down` is 1 for the following cycle, whatever the write inputs show.
- R6: The device is selected when all three `ce_n` inputs are low at a rising edge. In that case `pwr_down` is 0 in the very next cycle, so both entering and leaving power-down take effect in a single cycle.
- R7: `wr_mask` bits 9i+8 down to 9i equal `lane_wr[i]`. Lane 0 is bits 8:0, lane 1 is 17:9, lane 2 is 26:18 and lane 3 is 35:27.
- R8: Each strobe reflects only the controls sampled on the most recent edge. A write sampled on one edge followed by a read on the next gives a strobe exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 3 | Chip enables, all active-low, all must be low to select |
| gw_n | input | 1 | Global write, active-low, writes every lane |
| bwe_n | input | 1 | Byte-write enable, active-low, qualifies `bw_n` |
| bw_n | input | 4 | Per-lane byte selects, active-low, bit i is lane i |
| lane_wr | output | 4 | Registered per-lane write strobes, active-high |
| wr_mask | output | 36 | Registered per-bit write mask, lane strobes expanded 9 bits each |
| pwr_down | output | 1 | Registered deselect / low-power indication, active-high |

## Verification
The hardest case to reach is a set of conflicting controls arriving on the same edge, such as a global write while one chip enable is inactive. Another is a byte-write with an arbitrary lane subset right after a cycle that wrote different lanes. The bench drives every one of the 512 combinations of the nine control inputs on consecutive cycles. This ordering puts each case directly behind a different one, so a stale strobe shows up as an error. It also places every priority conflict between deselect, global write and byte write at the ports.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    localparam int LWD_LANES  = 4;
    localparam int LWD_LANE_W = 9;
    localparam int LWD_CE     = 3;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_READ = 2'd1,
        ACC_BYTE = 2'd2,
        ACC_ALL  = 2'd3
    } acc_e;

    function automatic acc_e classify(input logic sel, input logic gw_n,
                                      input logic bwe_n);
        acc_e k;
        if (!sel)        k = ACC_IDLE;
        else if (!gw_n)  k = ACC_ALL;
        else if (!bwe_n) k = ACC_BYTE;
        else             k = ACC_READ;
        return k;
    endfunction

    function automatic logic lane_strobe(input acc_e k, input logic sel_n);
        return (k == ACC_ALL) || ((k == ACC_BYTE) && !sel_n);
    endfunction

endpackage

// File: rtl/lwd_select.sv
module lwd_select #(
    parameter int NUM_CE = 3
) (
    input  logic [NUM_CE-1:0] ce_n,
    output logic              sel
);
    logic [NUM_CE:0] chain;
    assign chain[0] = 1'b1;

    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        assign chain[i+1] = chain[i] & ~ce_n[i];
    end

    assign sel = chain[NUM_CE];

    always_comb begin
        if (!$isunknown(ce_n))
            assert (sel == (ce_n == '0)); // R6
    end
endmodule

// File: rtl/lwd_lane_decode.sv
module lwd_lane_decode
    import lwd_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 sel,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [NUM_LANES-1:0] bw_n,
    output logic [NUM_LANES-1:0] lane_hit
);
    acc_e kind;
    assign kind = classify(sel, gw_n, bwe_n);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign lane_hit[i] = lane_strobe(kind, bw_n[i]);
    end
endmodule

// File: rtl/lwd_out_reg.sv
module lwd_out_reg #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 9,
    localparam int WORD_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic [NUM_LANES-1:0] lane_hit,
    output logic [NUM_LANES-1:0] lane_wr,
    output logic [WORD_W-1:0]    wr_mask,
    output logic                 pwr_down
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_wr  <= '0;
            pwr_down <= 1'b1;
        end else begin
            lane_wr  <= sel ? lane_hit : '0;
            pwr_down <= ~sel;
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) wr_mask[l*LANE_W +: LANE_W] <= '0;
            else     wr_mask[l*LANE_W +: LANE_W] <= {LANE_W{sel & lane_hit[l]}};
        end
    end

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (lane_wr == '0)); // R5

    AST_MASK_LANE0: assert property (@(posedge clk) disable iff (rst)
        wr_mask[LANE_W-1:0] == {LANE_W{lane_wr[0]}}); // R7
endmodule

// File: rtl/lane_wr_decode.sv
module lane_wr_decode
    import lwd_pkg::*;
#(
    parameter int NUM_LANES = LWD_LANES,
    parameter int LANE_W    = LWD_LANE_W,
    parameter int NUM_CE    = LWD_CE,
    localparam int WORD_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CE-1:0]    ce_n,
    input  logic                 gw_n,
    input  logic                 bwe_n,
    input  logic [NUM_LANES-1:0] bw_n,
    output logic [NUM_LANES-1:0] lane_wr,
    output logic [WORD_W-1:0]    wr_mask,
    output logic                 pwr_down
);
    logic                 sel;
    logic [NUM_LANES-1:0] lane_hit;

    lwd_select #(.NUM_CE(NUM_CE)) u_sel (
        .ce_n (ce_n),
        .sel  (sel)
    );

    lwd_lane_decode #(.NUM_LANES(NUM_LANES)) u_dec (
        .sel      (sel),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .lane_hit (lane_hit)
    );

    lwd_out_reg #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .lane_hit (lane_hit),
        .lane_wr  (lane_wr),
        .wr_mask  (wr_mask),
        .pwr_down (pwr_down)
    );

    AST_GW_ALL: assert property (@(posedge clk) disable iff (rst)
        ((ce_n == '0) && !gw_n) |=> (lane_wr == '1)); // R2

    AST_BYTE_SEL: assert property (@(posedge clk) disable iff (rst)
        ((ce_n == '0) && gw_n && !bwe_n) |=> (lane_wr == ~$past(bw_n))); // R3

    AST_READ_NONE: assert property (@(posedge clk) disable iff (rst)
        ((ce_n == '0) && gw_n && bwe_n) |=> (lane_wr == '0)); // R4

    AST_DESEL_PD: assert property (@(posedge clk) disable iff (rst)
        (ce_n != '0) |=> (pwr_down && lane_wr == '0)); // R5

    AST_WAKE_ONE: assert property (@(posedge clk) disable iff (rst)
        (ce_n == '0) |=> !pwr_down); // R6
endmodule

// File: tb/lane_wr_decode_tb.sv
module lane_wr_decode_tb;
    localparam int CLK_HALF = 5;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int NC = 3;
    localparam int WW = NL * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] ce_n;
    logic          gw_n, bwe_n;
    logic [NL-1:0] bw_n;
    logic [NL-1:0] lane_wr;
    logic [WW-1:0] wr_mask;
    logic          pwr_down;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #CLK_HALF clk = ~clk;

    lane_wr_decode u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .lane_wr(lane_wr), .wr_mask(wr_mask), .pwr_down(pwr_down)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] expand(input logic [NL-1:0] l);
        logic [WW-1:0] m;
        for (int b = 0; b < WW; b++) m[b] = l[b / LW];
        return m;
    endfunction

    task automatic drive(input logic [8:0] v);
        ce_n  = v[8:6];
        gw_n  = v[5];
        bwe_n = v[4];
        bw_n  = v[3:0];
    endtask

    initial begin
        rst = 1'b1;
        drive(9'h000);
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1", {63'd0, pwr_down}, 64'd1);
        check("R1", {60'd0, lane_wr}, 64'd0);
        check("R1", {28'd0, wr_mask}, 64'd0);
        rst = 1'b0;

        // exhaustive sweep of all 512 control combinations
        drive(9'd0);
        for (int k = 0; k < 512; k++) begin
            logic [8:0] v;
            logic [NL-1:0] exp_l;
            string tag;
            v = 9'(k);
            drive(v);
            @(negedge clk);
            if (v[8:6] != 3'b000) begin
                exp_l = '0; tag = "R5";
            end else if (!v[5]) begin
                exp_l = '1; tag = "R2";
            end else if (!v[4]) begin
                exp_l = ~v[3:0]; tag = "R3";
            end else begin
                exp_l = '0; tag = "R4";
            end
            check(tag, {60'd0, lane_wr}, {60'd0, exp_l});
            check((v[8:6] == 3'b000) ? "R6" : "R5", {63'd0, pwr_down},
                  {63'd0, (v[8:6] != 3'b000)});
            check("R7", {28'd0, wr_mask}, {28'd0, expand(exp_l)});
        end

        // R8: single write followed by read gives a one-cycle strobe
        drive(9'b000_1_0_0101);     // byte write on lanes 1 and 3
        @(negedge clk);
        check("R8", {60'd0, lane_wr}, 64'hA);
        drive(9'b000_1_1_0000);     // read
        @(negedge clk);
        check("R8", {60'd0, lane_wr}, 64'h0);
        // R6: deselect then reselect, each one cycle
        drive(9'b010_0_0_0000);
        @(negedge clk);
        check("R6", {63'd0, pwr_down}, 64'd1);
        drive(9'b000_0_1_1111);
        @(negedge clk);
        check("R6", {63'd0, pwr_down}, 64'd0);
        check("R2", {60'd0, lane_wr}, 64'hF);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (5000) @(posedge clk);
        join_any
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule